// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Recency-Ordered Cache

This block turns a 32-bit virtual address into a physical address for 4 KiB pages. The top 20 bits form the virtual page number and the low 12 bits are the byte offset inside the page. A small fully associative cache of recent mappings is searched in a single cycle. When a cached mapping matches, the physical frame number comes straight out of the cache, with no memory traffic.

On a miss the block walks a two-level table held in memory. The page number is split into a 10-bit directory index (address bits 31:22) and a 10-bit table index (address bits 21:12). The root of the tree is held in a base register, which software rewrites on every context switch. The fetched mapping is placed at the most-recent end of the cache, and the least recently used mapping falls out. A clear present bit at either level ends the walk with a fault.

Only one translation is in flight at a time. Cache hits can be issued back to back, one per cycle.

Top module: `vaddr_xlate`

## Requirements
- R1: The physical address is the 20-bit frame number in bits 31:12 followed by the unchanged virtual offset (virtual bits 11:0) in bits 11:0.
- R2: A request that matches a valid cached page is answered with rspValid in the cycle after it is accepted, with rspFault low. It makes no memory read, and reqReady stays high.
- R3: On a miss, the first memory read is at address {base[31:12], vaddr[31:22], 2'b00}.
- R4: When the directory word is present, the second read is at address {dirWord[31:12], vaddr[21:12], 2'b00}. The frame number is tableWord[31:12].
- R5: Bit 0 of a directory or table word is its present bit. If it is clear, the walk stops, rspFault is raised with rspPaddr zero, and nothing is cached. A repeat of that request walks again.
- R6: A walk that completes installs its mapping, so the next request to the same page hits.
- R7: The cache holds 8 entries kept in recency order. A hit makes its entry the most recent. A miss on a full cache evicts the least recently used entry.
- R8: A write to the base register invalidates every cached entry at once. A request accepted in the same cycle as the write is treated as a miss and walks from the new base.
- R9: From the acceptance of a miss until the cycle its response is presented, reqReady is low. Each memory read request lasts one cycle, and only one is outstanding at a time.
- R10: After reset, reqReady is high, rspValid and memRdValid are low, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| rspValid | output | 1 | Response valid for one cycle |
| rspPaddr | output | 32 | Physical address (zero on fault) |
| rspFault | output | 1 | Translation fault |
| memRdValid | output | 1 | Table-word read request, one cycle |
| memRdAddr | output | 32 | Byte address of the table word |
| memRdDataValid | input | 1 | Read data returned |
| memRdData | input | 32 | Returned table word |
| ptbWrEn | input | 1 | Write the table base register |
| ptbWrData | input | 32 | New table base (bits 31:12 used) |

## Verification
The assertions check these properties on every cycle:
- the directory-read address formed from the base and the request;
- offset passthrough on hits and on walk responses;
- zero addresses on faults;
- single-cycle read pulses while reqReady is low;
- that a response with no memory reads always follows an acceptance in the previous cycle.

Whether the frame numbers are right, the least-recently-used victim choice, the effect of a base switch and the suppression of installs after a fault all depend on history across many requests. Only the bench's scenarios show these. The bench checks them against an arithmetic model of the page table.

// File: rtl/vaddr_xlate_pkg.sv
package vaddr_xlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DIR_REQ  = 3'd1,
    ST_DIR_WAIT = 3'd2,
    ST_TBL_REQ  = 3'd3,
    ST_TBL_WAIT = 3'd4
  } walkState_t;

  // Strobes from control to datapath, valid for the current cycle.
  typedef struct packed {
    logic promote;   // hit: move matched entry to most-recent slot
    logic latchReq;  // miss: capture request address for the walk
    logic latchDir;  // directory word present: capture next-level base
    logic install;   // table word present: shift in new mapping
    logic issueRd;   // drive a memory read this cycle
    logic selTbl;    // read address is the table level
    logic rspHit;    // respond from cache
    logic rspWalk;   // respond from walk result
    logic rspFault;  // respond with fault
  } ctrlStrobe_t;

endpackage

// File: rtl/vaddr_xlate_ctrl.sv
module vaddr_xlate_ctrl
  import vaddr_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        lookupHit,
  input  logic        memRdDataValid,
  input  logic        descPresent,
  output logic        reqReady,
  output ctrlStrobe_t strb
);

  walkState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strb     = '0;
    reqReady = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          if (lookupHit) begin
            strb.promote = 1'b1;
            strb.rspHit  = 1'b1;
          end else begin
            strb.latchReq = 1'b1;
            stateD        = ST_DIR_REQ;
          end
        end
      end
      ST_DIR_REQ: begin
        strb.issueRd = 1'b1;
        stateD       = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        if (memRdDataValid) begin
          if (descPresent) begin
            strb.latchDir = 1'b1;
            stateD        = ST_TBL_REQ;
          end else begin
            strb.rspFault = 1'b1;
            stateD        = ST_IDLE;
          end
        end
      end
      ST_TBL_REQ: begin
        strb.issueRd = 1'b1;
        strb.selTbl  = 1'b1;
        stateD       = ST_TBL_WAIT;
      end
      ST_TBL_WAIT: begin
        strb.selTbl = 1'b1;
        if (memRdDataValid) begin
          if (descPresent) begin
            strb.install = 1'b1;
            strb.rspWalk = 1'b1;
          end else begin
            strb.rspFault = 1'b1;
          end
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/vaddr_xlate_dp.sv
module vaddr_xlate_dp
  import vaddr_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12,
  parameter int DIR_W    = 10,
  parameter int TBL_W    = 10,
  parameter int ENTRIES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              ptbWrEn,
  input  logic [ADDR_W-1:0] ptbWrData,
  input  logic [ADDR_W-1:0] memRdData,
  input  ctrlStrobe_t       strb,
  output logic              lookupHit,
  output logic              descPresent,
  output logic              memRdValid,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspFault
);

  localparam int VPN_W  = DIR_W + TBL_W;
  localparam int PFN_W  = ADDR_W - OFFSET_W;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int DPAD_W = OFFSET_W - DIR_W;
  localparam int TPAD_W = OFFSET_W - TBL_W;

  // Cache storage, slot 0 most recent, slot ENTRIES-1 least recent.
  logic [ENTRIES-1:0] entValid;
  logic [VPN_W-1:0]   entVpn [ENTRIES];
  logic [PFN_W-1:0]   entPfn [ENTRIES];

  logic [PFN_W-1:0]   ptbBase;
  logic [ADDR_W-1:0]  walkVaddr;
  logic [PFN_W-1:0]   dirBase;

  logic [VPN_W-1:0]   reqVpn;
  logic [VPN_W-1:0]   walkVpn;
  logic [DIR_W-1:0]   walkDirIdx;
  logic [TBL_W-1:0]   walkTblIdx;
  logic [PFN_W-1:0]   fetchedBase;
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   hitIdx;
  logic [PFN_W-1:0]   hitPfn;
  logic               unusedLowBits;

  assign reqVpn      = reqVaddr[ADDR_W-1:OFFSET_W];
  assign walkVpn     = walkVaddr[ADDR_W-1:OFFSET_W];
  assign walkDirIdx  = walkVaddr[ADDR_W-1 -: DIR_W];
  assign walkTblIdx  = walkVaddr[OFFSET_W +: TBL_W];
  assign fetchedBase = memRdData[ADDR_W-1:OFFSET_W];
  assign descPresent = memRdData[0];
  assign unusedLowBits = ^{ptbWrData[OFFSET_W-1:0], memRdData[OFFSET_W-1:1]};

  // Parallel compare against every slot.
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign matchVec[g] = entValid[g] && (entVpn[g] == reqVpn);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign hitPfn    = entPfn[hitIdx];
  // A base write in the same cycle hides all current entries.
  assign lookupHit = (|matchVec) && !ptbWrEn;

  // Base register and walk context.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptbBase   <= '0;
      walkVaddr <= '0;
      dirBase   <= '0;
    end else begin
      if (ptbWrEn)       ptbBase   <= ptbWrData[ADDR_W-1:OFFSET_W];
      if (strb.latchReq) walkVaddr <= reqVaddr;
      if (strb.latchDir) dirBase   <= fetchedBase;
    end
  end

  // Recency-ordered storage: install shifts everything down one slot,
  // promote shifts slots above the hit down and puts the hit on top.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entVpn[i] <= '0;
        entPfn[i] <= '0;
      end
    end else if (ptbWrEn) begin
      entValid <= '0;
    end else if (strb.install) begin
      entValid <= {entValid[ENTRIES-2:0], 1'b1};
      for (int i = ENTRIES - 1; i > 0; i--) begin
        entVpn[i] <= entVpn[i-1];
        entPfn[i] <= entPfn[i-1];
      end
      entVpn[0] <= walkVpn;
      entPfn[0] <= fetchedBase;
    end else if (strb.promote) begin
      for (int i = ENTRIES - 1; i > 0; i--) begin
        if (i <= int'(hitIdx)) begin
          entVpn[i] <= entVpn[i-1];
          entPfn[i] <= entPfn[i-1];
        end
      end
      entVpn[0] <= reqVpn;
      entPfn[0] <= hitPfn;
    end
  end

  // Memory read port.
  assign memRdValid = strb.issueRd;
  assign memRdAddr  = strb.selTbl ? {dirBase, walkTblIdx, {TPAD_W{1'b0}}}
                                  : {ptbBase, walkDirIdx, {DPAD_W{1'b0}}};

  // Registered response.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspPaddr <= '0;
      rspFault <= 1'b0;
    end else begin
      rspValid <= strb.rspHit || strb.rspWalk || strb.rspFault;
      rspFault <= strb.rspFault;
      if (strb.rspHit)
        rspPaddr <= {hitPfn, reqVaddr[OFFSET_W-1:0]};
      else if (strb.rspWalk)
        rspPaddr <= {fetchedBase, walkVaddr[OFFSET_W-1:0]};
      else
        rspPaddr <= '0;
    end
  end

endmodule

// File: rtl/vaddr_xlate.sv
module vaddr_xlate
  import vaddr_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12,
  parameter int DIR_W    = 10,
  parameter int TBL_W    = 10,
  parameter int ENTRIES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspFault,
  output logic              memRdValid,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdDataValid,
  input  logic [ADDR_W-1:0] memRdData,
  input  logic              ptbWrEn,
  input  logic [ADDR_W-1:0] ptbWrData
);

  ctrlStrobe_t strb;
  logic        lookupHit;
  logic        descPresent;

  vaddr_xlate_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .lookupHit      (lookupHit),
    .memRdDataValid (memRdDataValid),
    .descPresent    (descPresent),
    .reqReady       (reqReady),
    .strb           (strb)
  );

  vaddr_xlate_dp #(
    .ADDR_W   (ADDR_W),
    .OFFSET_W (OFFSET_W),
    .DIR_W    (DIR_W),
    .TBL_W    (TBL_W),
    .ENTRIES  (ENTRIES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqVaddr    (reqVaddr),
    .ptbWrEn     (ptbWrEn),
    .ptbWrData   (ptbWrData),
    .memRdData   (memRdData),
    .strb        (strb),
    .lookupHit   (lookupHit),
    .descPresent (descPresent),
    .memRdValid  (memRdValid),
    .memRdAddr   (memRdAddr),
    .rspValid    (rspValid),
    .rspPaddr    (rspPaddr),
    .rspFault    (rspFault)
  );

endmodule

// File: rtl/vaddr_xlate_chk.sv
module vaddr_xlate_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12,
  parameter int DIR_W    = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqVaddr,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic              rspFault,
  input logic              memRdValid,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              ptbWrEn,
  input logic [ADDR_W-1:0] ptbWrData
);

  localparam int DPAD_W = OFFSET_W - DIR_W;

  logic              accept;
  logic [ADDR_W-1:0] lastVaddr;
  logic [ADDR_W-1:0] ptbShadow;
  logic [1:0]        readsSince;
  logic              pending;

  assign accept = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastVaddr  <= '0;
      ptbShadow  <= '0;
      readsSince <= '0;
      pending    <= 1'b0;
    end else begin
      if (ptbWrEn) ptbShadow <= ptbWrData;
      if (accept) begin
        lastVaddr  <= reqVaddr;
        readsSince <= '0;
      end else if (memRdValid && readsSince != 2'd3) begin
        readsSince <= readsSince + 2'd1;
      end
      if (accept)        pending <= 1'b1;
      else if (rspValid) pending <= 1'b0;
    end
  end

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspPaddr == '0); // R5

  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault && readsSince == 2'd0 |->
      rspPaddr[OFFSET_W-1:0] == $past(reqVaddr[OFFSET_W-1:0])); // R1

  AST_WALK_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault && readsSince != 2'd0 |->
      rspPaddr[OFFSET_W-1:0] == lastVaddr[OFFSET_W-1:0]); // R1

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && readsSince == 2'd0 && !rspFault |-> $past(accept)); // R2

  AST_DIR_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && readsSince == 2'd0 |->
      memRdAddr == {ptbShadow[ADDR_W-1:OFFSET_W],
                    lastVaddr[ADDR_W-1 -: DIR_W], {DPAD_W{1'b0}}}); // R3

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |=> !memRdValid); // R9

  AST_RD_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> !reqReady); // R9

  AST_RSP_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> pending); // R9

endmodule

bind vaddr_xlate vaddr_xlate_chk #(
  .ADDR_W   (ADDR_W),
  .OFFSET_W (OFFSET_W),
  .DIR_W    (DIR_W)
) i_vaddrXlateChk (.*);

// File: tb/test_vaddr_xlate.sv
module test_vaddr_xlate;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic        rspFault;
  logic        memRdValid;
  logic [31:0] memRdAddr;
  logic        memRdDataValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        ptbWrEn = 1'b0;
  logic [31:0] ptbWrData = '0;

  int checks = 0;
  int failures = 0;
  int rdCount = 0;
  logic [31:0] rdLog [4];
  logic [31:0] curBase = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vaddr_xlate i_vaddr_xlate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspFault(rspFault), .memRdValid(memRdValid), .memRdAddr(memRdAddr),
    .memRdDataValid(memRdDataValid), .memRdData(memRdData),
    .ptbWrEn(ptbWrEn), .ptbWrData(ptbWrData)
  );

  // Arithmetic page-table contents; index 0x3FF at any level is not present.
  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [19:0] b;
    b = a[31:12] * 20'd3 + {10'd0, a[11:2]} + 20'h00123;
    return {b, 11'd0, (a[11:2] != 10'h3FF)};
  endfunction

  function automatic logic [31:0] pageVa(input int p, input int off);
    logic [9:0] d, t;
    d = 10'((p * 37 + 1) % 1024);
    t = 10'((p * 53 + 2) % 1024);
    return {d, t, 12'(off)};
  endfunction

  // Memory responder: one cycle after the request, data for one cycle.
  initial begin
    logic [31:0] a;
    @(negedge clk);
    forever begin
      if (memRdValid === 1'b1) begin
        a = memRdAddr;
        rdLog[rdCount % 4] = a;
        rdCount++;
        @(negedge clk);
        memRdDataValid = 1'b1;
        memRdData = memWord(a);
        @(negedge clk);
        memRdDataValid = 1'b0;
        memRdData = '0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeBase(input logic [31:0] b);
    ptbWrEn = 1'b1;
    ptbWrData = b;
    @(negedge clk);
    ptbWrEn = 1'b0;
    curBase = b;
  endtask

  // Issue one request, optionally with a base write in the same cycle,
  // and compare with the model. expHit selects hit or walk expectations.
  task automatic xlate(input logic [31:0] va, input bit expHit, input bit wrBase,
                       input logic [31:0] newBase, input string tag);
    logic [31:0] dA, tA, dW, tW, expPa;
    bit expFault;
    int expReads, rdStart, lat;
    bit readyLow;
    while (!reqReady) @(negedge clk);
    if (wrBase) begin
      ptbWrEn = 1'b1;
      ptbWrData = newBase;
      curBase = newBase;
    end
    dA = {curBase[31:12], va[31:22], 2'b00};
    dW = memWord(dA);
    tA = {dW[31:12], va[21:12], 2'b00};
    tW = memWord(tA);
    expFault = !dW[0] || !tW[0];
    expReads = !dW[0] ? 1 : 2;
    expPa = expFault ? 32'h0 : {tW[31:12], va[11:0]};
    rdStart = rdCount;
    reqValid = 1'b1;
    reqVaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
    ptbWrEn = 1'b0;
    readyLow = !reqReady;
    lat = 1;
    while (!rspValid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    check(rspValid == 1'b1, {tag, " response"}, 32'(rspValid), 32'd1);
    check(rspPaddr == expPa, {tag, " paddr"}, rspPaddr, expPa);
    check(rspFault == expFault, {tag, " fault"}, 32'(rspFault), 32'(expFault));
    if (expHit) begin
      check(rdCount == rdStart, {tag, " R2 no reads on hit"}, 32'(rdCount - rdStart), 32'd0);
      check(lat == 1, {tag, " R2 hit latency"}, 32'(lat), 32'd1);
      check(!readyLow, {tag, " R2 ready stays high"}, 32'(readyLow), 32'd0);
    end else begin
      check(rdCount - rdStart == expReads, {tag, " walk read count"},
            32'(rdCount - rdStart), 32'(expReads));
      check(rdLog[rdStart % 4] == dA, {tag, " R3 directory address"},
            rdLog[rdStart % 4], dA);
      if (expReads == 2)
        check(rdLog[(rdStart + 1) % 4] == tA, {tag, " R4 table address"},
              rdLog[(rdStart + 1) % 4], tA);
      check(readyLow, {tag, " R9 ready low during walk"}, 32'(readyLow), 32'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R10 reset ready", 32'(reqReady), 32'd1);
    check(rspValid == 1'b0, "R10 reset rspValid", 32'(rspValid), 32'd0);
    check(memRdValid == 1'b0, "R10 reset memRdValid", 32'(memRdValid), 32'd0);

    writeBase(32'h0040_0000);
    // R10: cache empty after reset, so first touches walk.
    for (int p = 0; p < 8; p++) xlate(pageVa(p, p * 291), 1'b0, 1'b0, 0, "R6 R10 first touch");
    // R1, R6: every installed page now hits, with varied offsets.
    for (int p = 0; p < 8; p++) xlate(pageVa(p, 4095 - p * 17), 1'b1, 1'b0, 0, "R1 R6 hit");

    // R7: refresh pages 1..7, leaving page 0 least recent.
    for (int p = 1; p < 8; p++) xlate(pageVa(p, p), 1'b1, 1'b0, 0, "R7 refresh");
    xlate(pageVa(8, 5), 1'b0, 1'b0, 0, "R7 ninth page");
    for (int p = 1; p < 8; p++) xlate(pageVa(p, 9), 1'b1, 1'b0, 0, "R7 survivors");
    xlate(pageVa(0, 6), 1'b0, 1'b0, 0, "R7 evicted page");
    xlate(pageVa(8, 7), 1'b0, 1'b0, 0, "R7 second eviction");
    xlate(pageVa(0, 8), 1'b1, 1'b0, 0, "R7 reinstalled");

    // R5: directory-level and table-level faults, never installed.
    xlate({10'h3FF, 10'd4, 12'h0AB}, 1'b0, 1'b0, 0, "R5 dir fault");
    xlate({10'h3FF, 10'd4, 12'h0AC}, 1'b0, 1'b0, 0, "R5 dir fault repeat");
    xlate({10'd5, 10'h3FF, 12'h123}, 1'b0, 1'b0, 0, "R5 table fault");
    xlate({10'd5, 10'h3FF, 12'h124}, 1'b0, 1'b0, 0, "R5 table fault repeat");

    // R8: base switch flushes cached mappings.
    writeBase(32'h0080_0000);
    xlate(pageVa(2, 16), 1'b0, 1'b0, 0, "R8 after base write");
    xlate(pageVa(2, 17), 1'b1, 1'b0, 0, "R8 new context hit");
    xlate(pageVa(2, 18), 1'b0, 1'b1, 32'h00C0_0000, "R8 same-cycle write");
    // R1: offset sweep on a cached page, back to back.
    for (int o = 0; o < 4096; o += 455) xlate(pageVa(2, o), 1'b1, 1'b0, 0, "R1 offset sweep");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule